// File: doc/BRIEF.md
# Interrupt Arbitration and Cause Encoding Unit

This unit decides, once per clock, whether a hardware thread has to enter an interrupt trap and, if it does, which interrupt is serviced. It looks at the pending vector and the per-line enable vector, a per-line delegation mask, the current privilege level, and the machine and supervisor global enable bits. Each interrupt line is handled either at machine level or at supervisor level. Each group is then gated by its own privilege rule. The lowest-numbered line that survives the gating wins.

An auxiliary injection stream lets a coprocessor present a one-hot interrupt mask. In the cycle where an injection is offered, that mask is used in place of the pending-and-enable vector. It passes through the same gating. If nothing survives, an error flag is raised instead of a trap.

All results are registered. The trap strobe, cause word and error flag are valid one clock after the inputs are sampled. The injection stream uses a valid signal only and is always accepted. It never applies back-pressure, because every offered mask is evaluated in the cycle it is presented and the result appears one cycle later. A source that wants a second evaluation presents the mask again.

Top module: `irq_arbiter`

## Requirements
- R1: While `rst_n` is low, and after its release until the first evaluation, `trap_take`, `trap_cause` and `inj_err` are all zero.
- R2: When `inj_valid` is low, the candidate set is `irq_pend & irq_en`. A line that is pending but not enabled, or enabled but not pending, never causes a trap.
- R3: Machine-level handling is open when `priv` is below 3, or when `priv` is 3 and `m_gie` is 1. The privilege encoding is 0 user, 1 supervisor, 3 machine, and 2 is reserved and treated as below machine.
- R4: A candidate line whose `irq_deleg` bit is 0 is eligible only when machine-level handling is open.
- R5: A candidate line whose `irq_deleg` bit is 1 is eligible only when supervisor handling is open. That is the case when `priv` is 0, or when `priv` is 1 and `s_gie` is 1. Supervisor handling is never open when `priv` is 2 or 3.
- R6: When several lines are eligible, the one with the lowest index is selected.
- R7: On a trap, `trap_cause` has bit XLEN-1 set, holds the selected index in its low $clog2(NIRQ) bits, and has all other bits zero. Without a trap, `trap_cause` is zero.
- R8: When `inj_valid` is high, `inj_mask` replaces `irq_pend & irq_en` for that evaluation, with the same delegation and privilege gating applied.
- R9: When `inj_valid` is high and no injected line is eligible, `inj_err` is 1 and `trap_take` is 0. `inj_err` is never 1 in a cycle where `inj_valid` was low.
- R10: Outputs reflect the inputs sampled at the previous rising clock edge, with exactly one cycle of latency. No trap is signalled when the eligible set is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pend | input | NIRQ | Pending interrupt lines |
| irq_en | input | NIRQ | Per-line enables |
| irq_deleg | input | NIRQ | 1 = line handled at supervisor level |
| priv | input | 2 | Current privilege (0 U, 1 S, 3 M) |
| m_gie | input | 1 | Machine global interrupt enable |
| s_gie | input | 1 | Supervisor global interrupt enable |
| inj_valid | input | 1 | Injection offered this cycle (always accepted) |
| inj_mask | input | NIRQ | Injected interrupt mask, expected one-hot |
| trap_take | output | 1 | Trap must be taken |
| trap_cause | output | XLEN | Interrupt flag plus selected index |
| inj_err | output | 1 | Injection offered but not eligible |

## Verification
The assertions assume that `priv`, the enable bits and the vectors are stable around the sampling edge. They also assume that reset is released only away from a clock edge. The bench drives every input on the falling edge, so each value is settled well before the next rising edge. The error-flag checks take for granted that the injected mask is one-hot or zero. The bench builds injected masks only by shifting a single bit, or uses an all-zero mask, so this assumption always holds. It visits all four privilege codes, including the reserved one.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  typedef enum logic [1:0] {
    LVL_USER  = 2'd0,
    LVL_SUPV  = 2'd1,
    LVL_RSVD  = 2'd2,
    LVL_MACH  = 2'd3
  } lvl_e;
endpackage

// File: rtl/irq_gate.sv
module irq_gate
  import irq_arb_pkg::*;
#(
  parameter int NIRQ = 16
) (
  input  logic [NIRQ-1:0] cand,
  input  logic [NIRQ-1:0] deleg,
  input  logic [1:0]      priv,
  input  logic            m_gie,
  input  logic            s_gie,
  output logic [NIRQ-1:0] elig
);
  logic m_open;
  logic s_open;

  always_comb begin
    m_open = (priv != LVL_MACH) || m_gie;
    s_open = (priv == LVL_USER) || ((priv == LVL_SUPV) && s_gie);
  end

  for (genvar g = 0; g < NIRQ; g++) begin : g_line
    assign elig[g] = cand[g] & (deleg[g] ? s_open : m_open);
  end

  always_comb begin
    // R5
    s_closed_chk: assert ((priv != LVL_MACH && priv != LVL_RSVD) ||
                          ((elig & deleg) == '0));
  end
endmodule

// File: rtl/irq_lowest.sv
module irq_lowest #(
  parameter int NIRQ = 16,
  localparam int IDXW = $clog2(NIRQ)
) (
  input  logic [NIRQ-1:0] vec,
  output logic            found,
  output logic [IDXW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = NIRQ - 1; i >= 0; i--) begin
      if (vec[i]) begin
        found = 1'b1;
        idx   = IDXW'(i);
      end
    end
  end

  always_comb begin
    // R6
    lowest_wins_chk: assert (!found || (vec[idx] &&
                     ((vec & ((NIRQ'(1) << idx) - NIRQ'(1))) == '0)));
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_arb_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int NIRQ = 16,
  localparam int IDXW = $clog2(NIRQ)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NIRQ-1:0]  irq_pend,
  input  logic [NIRQ-1:0]  irq_en,
  input  logic [NIRQ-1:0]  irq_deleg,
  input  logic [1:0]       priv,
  input  logic             m_gie,
  input  logic             s_gie,
  input  logic             inj_valid,
  input  logic [NIRQ-1:0]  inj_mask,
  output logic             trap_take,
  output logic [XLEN-1:0]  trap_cause,
  output logic             inj_err
);
  logic [NIRQ-1:0] cand;
  logic [NIRQ-1:0] elig;
  logic            hit;
  logic [IDXW-1:0] win;

  assign cand = inj_valid ? inj_mask : (irq_pend & irq_en);

  irq_gate #(.NIRQ(NIRQ)) u_gate (
    .cand (cand),
    .deleg(irq_deleg),
    .priv (priv),
    .m_gie(m_gie),
    .s_gie(s_gie),
    .elig (elig)
  );

  irq_lowest #(.NIRQ(NIRQ)) u_pick (
    .vec  (elig),
    .found(hit),
    .idx  (win)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trap_take  <= 1'b0;
      trap_cause <= '0;
      inj_err    <= 1'b0;
    end else begin
      trap_take  <= hit;
      trap_cause <= hit ? {1'b1, {(XLEN-1-IDXW){1'b0}}, win} : '0;
      inj_err    <= inj_valid && !hit;
    end
  end

  // R7
  cause_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_take |-> trap_cause[XLEN-1]);
  // R7
  cause_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_take |-> (trap_cause == '0));
  // R9
  err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(trap_take && inj_err));
  // R9
  err_needs_inj_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !inj_valid |=> !inj_err);
  // R3
  mach_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (priv == LVL_MACH && !m_gie) |=> !trap_take);
  // R10
  empty_no_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!inj_valid && (irq_pend & irq_en) == '0) |=> !trap_take);
endmodule

// File: tb/irq_arbiter_test.sv
module irq_arbiter_test;
  localparam int XLEN = 64;
  localparam int NIRQ = 16;
  localparam int IDXW = $clog2(NIRQ);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NIRQ-1:0] irq_pend = '0, irq_en = '0, irq_deleg = '0, inj_mask = '0;
  logic [1:0] priv = 2'd3;
  logic m_gie = 1'b0, s_gie = 1'b0, inj_valid = 1'b0;
  logic trap_take, inj_err;
  logic [XLEN-1:0] trap_cause;

  int checks = 0;
  int fails = 0;
  string tag = "R1";
  bit done = 1'b0;

  logic exp_take = 1'b0, exp_err = 1'b0;
  logic [XLEN-1:0] exp_cause = '0;

  always #2 clk = ~clk;

  irq_arbiter #(.XLEN(XLEN), .NIRQ(NIRQ)) uut (
    .clk(clk), .rst_n(rst_n), .irq_pend(irq_pend), .irq_en(irq_en),
    .irq_deleg(irq_deleg), .priv(priv), .m_gie(m_gie), .s_gie(s_gie),
    .inj_valid(inj_valid), .inj_mask(inj_mask), .trap_take(trap_take),
    .trap_cause(trap_cause), .inj_err(inj_err)
  );

  function automatic void model(output logic t, output logic [XLEN-1:0] c,
                                output logic e);
    logic [NIRQ-1:0] set;
    bit m_ok, s_ok;
    int pick;
    set  = inj_valid ? inj_mask : (irq_pend & irq_en);
    m_ok = (priv < 2'd3) || m_gie;
    s_ok = (priv == 2'd0) || (priv == 2'd1 && s_gie);
    pick = -1;
    for (int i = 0; i < NIRQ; i++)
      if (pick < 0 && set[i] && (irq_deleg[i] ? s_ok : m_ok)) pick = i;
    t = (pick >= 0);
    c = '0;
    if (t) begin
      c[XLEN-1] = 1'b1;
      c = c | XLEN'(pick);
    end
    e = inj_valid && !t;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      exp_take = 1'b0; exp_cause = '0; exp_err = 1'b0;
    end else begin
      model(exp_take, exp_cause, exp_err);
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (trap_take !== exp_take || trap_cause !== exp_cause || inj_err !== exp_err) begin
        fails++;
        $display("FAIL %s: got take=%0b cause=%h err=%0b, expected take=%0b cause=%h err=%0b",
                 tag, trap_take, trap_cause, inj_err, exp_take, exp_cause, exp_err);
      end
    end
  end

  task automatic step(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic drive(input logic [NIRQ-1:0] p, e, d, input logic [1:0] pv,
                       input logic mg, sg, iv, input logic [NIRQ-1:0] im);
    irq_pend = p; irq_en = e; irq_deleg = d; priv = pv;
    m_gie = mg; s_gie = sg; inj_valid = iv; inj_mask = im;
    step(1);
  endtask

  initial begin
    #100000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got hang, expected completion");
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    tag = "R1";
    irq_pend = '1; irq_en = '1; priv = 2'd0;
    step(3);
    rst_n = 1'b1;
    step(1);
    tag = "R2";
    drive(16'h00F0, 16'h0F00, 16'h0000, 2'd0, 0, 0, 0, 0);
    drive(16'h0F00, 16'h0F00, 16'h0000, 2'd0, 0, 0, 0, 0);
    tag = "R3";
    drive(16'h0004, 16'hFFFF, 16'h0000, 2'd3, 0, 1, 0, 0);
    drive(16'h0004, 16'hFFFF, 16'h0000, 2'd3, 1, 0, 0, 0);
    drive(16'h0004, 16'hFFFF, 16'h0000, 2'd2, 0, 0, 0, 0);
    tag = "R4";
    drive(16'h0008, 16'hFFFF, 16'h0000, 2'd1, 0, 0, 0, 0);
    drive(16'h0008, 16'hFFFF, 16'h0008, 2'd3, 1, 1, 0, 0);
    tag = "R5";
    drive(16'h0020, 16'hFFFF, 16'h0020, 2'd0, 0, 0, 0, 0);
    drive(16'h0020, 16'hFFFF, 16'h0020, 2'd1, 1, 0, 0, 0);
    drive(16'h0020, 16'hFFFF, 16'h0020, 2'd1, 0, 1, 0, 0);
    drive(16'h0020, 16'hFFFF, 16'h0020, 2'd2, 1, 1, 0, 0);
    tag = "R6";
    drive(16'h8422, 16'hFFFF, 16'h0002, 2'd1, 0, 0, 0, 0);
    drive(16'hFFFF, 16'hFFFF, 16'h0000, 2'd0, 0, 0, 0, 0);
    tag = "R7";
    drive(16'h8000, 16'hFFFF, 16'h0000, 2'd0, 0, 0, 0, 0);
    tag = "R8";
    drive(16'h0001, 16'hFFFF, 16'h0000, 2'd0, 0, 0, 1, 16'h0400);
    drive(16'h0000, 16'h0000, 16'h0400, 2'd1, 0, 1, 1, 16'h0400);
    tag = "R9";
    drive(16'h0001, 16'hFFFF, 16'h0000, 2'd3, 0, 0, 1, 16'h0002);
    drive(16'h0001, 16'hFFFF, 16'h0000, 2'd0, 0, 0, 1, 16'h0000);
    tag = "R10";
    drive(16'h0000, 16'hFFFF, 16'h0000, 2'd0, 1, 1, 0, 0);
    drive(16'h0010, 16'hFFFF, 16'h0000, 2'd0, 1, 1, 0, 0);
    drive(16'h0000, 16'hFFFF, 16'h0000, 2'd0, 1, 1, 0, 0);
    tag = "R2";
    for (int n = 0; n < 3000; n++) begin
      logic [NIRQ-1:0] im;
      logic iv;
      iv = ($urandom_range(0, 3) == 0);
      im = ($urandom_range(0, 5) == 0) ? '0 : (NIRQ'(1) << $urandom_range(0, NIRQ - 1));
      drive(NIRQ'($urandom), NIRQ'($urandom), NIRQ'($urandom),
            2'($urandom_range(0, 3)), 1'($urandom), 1'($urandom), iv, im);
    end
    tag = "R1";
    rst_n = 1'b0;
    step(2);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule